// File: doc/BRIEF.md
# Multi-Context Programmable Sum-of-Products Array

This block is a programmable AND-OR array with 22 logic inputs and 10 logic outputs. Each product term takes the AND of any chosen subset of the 44 literals, which are every input in true and complemented form. Each output takes the OR of any chosen subset of its own group of product terms. An output cell then passes that sum either straight through or through a flip-flop, in true or inverted polarity.

Every programmable node is a 2:1 selector steered by its own configuration flip-flop. An external context controller replaces the whole personality while the array runs. It writes 32-bit words into one flat configuration address space. A `hold` input freezes the output registers, so registered outputs stay quiet while a new context is streamed in.

Top module: `pla_ctx_array`

## Requirements
- R1: Literal l of product term t is input l/2 in true form when l is even and complemented when l is odd. A term is the AND of the literals whose node bits are 1.
- R2: A node whose bit is 0 is neutral. In the AND plane it gives 1, so a term with no literal selected is 1. In the OR plane it gives 0, so an output with no term enabled sums to 0.
- R3: Output j owns 8 + 2*floor(j/2) product terms, numbered consecutively from output 0 upward. That gives 120 terms in total: outputs 0 and 1 have 8 terms each, and outputs 8 and 9 have 16 each.
- R4: Configuration bit map. The AND node for term t and literal l is bit t*44+l. The OR enable of term t is bit 5280+t. For output j, bit 5400+2j selects inversion and bit 5401+2j selects the registered path. Bit b is held in word b/32 at position b%32.
- R5: A write to word k replaces all 32 bits of that word at the rising edge. Writes to addresses 170 and above change nothing. Bits of word 169 beyond bit 5419 are ignored.
- R6: The output mode is {registered, invert}. 00 gives the combinational sum, 01 its complement, 10 the registered sum, and 11 the complement of the registered sum.
- R7: Each output register loads its sum at a rising edge when `hold` is 0, and keeps its value when `hold` is 1.
- R8: A configuration write reaches the combinational outputs just after its write edge. The registered outputs capture a sum built from the new configuration at the following edge.
- R9: An active-low reset clears all configuration bits and output registers, so every output reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| hold | input | 1 | Freezes the output registers when 1 |
| din | input | 22 | Logic inputs |
| cfg_we | input | 1 | Configuration word write enable |
| cfg_addr | input | 8 | Configuration word address |
| cfg_data | input | 32 | Configuration word data |
| dout | output | 10 | Logic outputs |

## Verification
The assertions assume that `din`, `hold` and the configuration port always carry known values. They also assume these inputs change only between rising edges, so that a stable input vector together with no write leaves every sum unchanged. The bench applies all stimulus at the falling edge and holds it for the whole cycle. The bench also releases reset away from a rising edge and keeps `cfg_we` low during reset and the first cycle after it.

// File: rtl/pla_ctx_array.sv
module pla_ctx_array #(
  parameter int N_IN   = 22,
  parameter int N_OUT  = 10,
  parameter int T_MIN  = 8,
  parameter int T_STEP = 2,
  parameter int CFG_W  = 32,
  localparam int N_TERM   = N_OUT*T_MIN + T_STEP*(N_OUT/2)*((N_OUT-1)/2),
  localparam int LITS     = 2*N_IN,
  localparam int AND_BITS = N_TERM*LITS,
  localparam int MODE_LO  = AND_BITS + N_TERM,
  localparam int CFG_BITS = MODE_LO + 2*N_OUT,
  localparam int N_WORDS  = (CFG_BITS + CFG_W - 1) / CFG_W,
  localparam int ADDR_W   = $clog2(N_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold,
  input  logic [N_IN-1:0]   din,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [CFG_W-1:0]  cfg_data,
  output logic [N_OUT-1:0]  dout
);

  function automatic int tcount(int j);
    return T_MIN + T_STEP*(j/2);
  endfunction

  function automatic int tbase(int j);
    int s = 0;
    for (int k = 0; k < j; k++) s += tcount(k);
    return s;
  endfunction

  logic [CFG_BITS-1:0] cfg_q;
  logic [LITS-1:0]     lit;
  logic [N_TERM-1:0]   pterm;
  logic [N_OUT-1:0]    sum;
  logic [N_OUT-1:0]    reg_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (cfg_we && int'(cfg_addr) < N_WORDS) begin
      for (int b = 0; b < CFG_W; b++)
        if (int'(cfg_addr)*CFG_W + b < CFG_BITS)
          cfg_q[int'(cfg_addr)*CFG_W + b] <= cfg_data[b];
    end
  end

  for (genvar i = 0; i < N_IN; i++) begin : g_lit
    assign lit[2*i]   = din[i];
    assign lit[2*i+1] = ~din[i];
  end

  for (genvar t = 0; t < N_TERM; t++) begin : g_and
    assign pterm[t] = &(lit | ~cfg_q[t*LITS +: LITS]);
  end

  for (genvar j = 0; j < N_OUT; j++) begin : g_out
    localparam int B = tbase(j);
    localparam int C = tcount(j);
    logic inv, use_reg;
    assign sum[j]  = |(pterm[B +: C] & cfg_q[AND_BITS + B +: C]);
    assign inv     = cfg_q[MODE_LO + 2*j];
    assign use_reg = cfg_q[MODE_LO + 2*j + 1];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     reg_q[j] <= 1'b0;
      else if (!hold) reg_q[j] <= sum[j];
    end

    assign dout[j] = (use_reg ? reg_q[j] : sum[j]) ^ inv;
  end

endmodule

// File: rtl/pla_ctx_array_chk.sv
module pla_ctx_array_chk #(
  parameter int N_IN   = 22,
  parameter int N_OUT  = 10,
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              hold,
  input logic [N_IN-1:0]   din,
  input logic              cfg_we,
  input logic [ADDR_W-1:0] cfg_addr,
  input logic [N_OUT-1:0]  comb_sum,
  input logic [N_OUT-1:0]  reg_q,
  input logic [N_OUT-1:0]  dout
);

  a_r7_hold_freezes: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> $stable(reg_q));

  a_r7_capture_sum: assert property (@(posedge clk) disable iff (!rst_n)
    !hold |=> reg_q == $past(comb_sum));

  a_r9_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (reg_q == '0 && dout == '0));

  a_r8_sum_needs_cause: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(cfg_we) && $stable(din)) |-> $stable(comb_sum));

endmodule

bind pla_ctx_array pla_ctx_array_chk #(
  .N_IN(N_IN), .N_OUT(N_OUT), .ADDR_W(ADDR_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .hold(hold), .din(din),
  .cfg_we(cfg_we), .cfg_addr(cfg_addr),
  .comb_sum(sum), .reg_q(reg_q), .dout(dout)
);

// File: tb/pla_ctx_array_tb.sv
module pla_ctx_array_tb_top;
  localparam int NI = 22, NO = 10, NT = 120, NB = 5420, NW = 170;
  localparam int ORB = 5280, MDB = 5400;

  logic clk = 1'b0, rst_n = 1'b0, hold = 1'b0, cfg_we = 1'b0;
  logic [21:0] din = '0;
  logic [7:0]  cfg_addr = '0;
  logic [31:0] cfg_data = '0;
  logic [9:0]  dout;

  logic [NB-1:0] mcfg = '0;
  logic [NO-1:0] mreg = '0;
  int total = 0, bad = 0;

  always #10 clk = ~clk;

  pla_ctx_array dut_i (.clk(clk), .rst_n(rst_n), .hold(hold), .din(din),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_data(cfg_data), .dout(dout));

  function automatic logic msum(int j, logic [21:0] d);
    int base = 0;
    logic s = 1'b0;
    for (int k = 0; k < j; k++) base += 8 + 2*(k/2);
    for (int t = base; t < base + 8 + 2*(j/2); t++) begin
      logic p = 1'b1;
      for (int l = 0; l < 2*NI; l++)
        if (mcfg[t*2*NI + l]) p = p & ((l % 2) ? ~d[l/2] : d[l/2]);
      if (mcfg[ORB + t]) s = s | p;
    end
    return s;
  endfunction

  function automatic logic [NO-1:0] mout(logic [21:0] d);
    logic [NO-1:0] o;
    for (int j = 0; j < NO; j++)
      o[j] = (mcfg[MDB+2*j+1] ? mreg[j] : msum(j, d)) ^ mcfg[MDB+2*j];
    return o;
  endfunction

  task automatic cyc(input bit we, input int addr, input logic [31:0] data,
                     input bit hd, input logic [21:0] d, input string req);
    logic [NO-1:0] exp, s;
    @(negedge clk);
    cfg_we = we; cfg_addr = addr[7:0]; cfg_data = data; hold = hd; din = d;
    #5;
    exp = mout(d);
    total++;
    if (dout !== exp) begin
      bad++;
      $display("FAIL %s dout=%b exp=%b", req, dout, exp);
    end
    @(posedge clk);
    for (int j = 0; j < NO; j++) s[j] = msum(j, d);
    if (!hd) mreg = s;
    if (we && (addr % 256) < NW)
      for (int b = 0; b < 32; b++)
        if (addr*32 + b < NB) mcfg[addr*32 + b] = data[b];
  endtask

  task automatic setbit(input int b, input logic v, input string req);
    logic [31:0] w;
    int a = b / 32;
    for (int k = 0; k < 32; k++) w[k] = (a*32 + k < NB) ? mcfg[a*32 + k] : 1'b0;
    w[b % 32] = v;
    cyc(1'b1, a, w, 1'b0, 22'($urandom), req);
  endtask

  task automatic idle(input int n, input bit hd, input string req);
    for (int i = 0; i < n; i++) cyc(1'b0, 0, 32'h0, hd, 22'($urandom), req);
  endtask

  initial begin
    #4000000;
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    // R9: everything cleared after reset
    idle(6, 1'b0, "R9");
    // R1: output 0 = in0 & ~in1 (literals 0 and 3 of term 0)
    setbit(0, 1'b1, "R1");
    setbit(3, 1'b1, "R1");
    setbit(ORB + 0, 1'b1, "R8");
    idle(20, 1'b0, "R1");
    cyc(1'b0, 0, 0, 1'b0, 22'h000001, "R1");
    cyc(1'b0, 0, 0, 1'b0, 22'h000003, "R1");
    // R2: empty term enabled on output 1 is 1; empty output 2 inverted is 1
    setbit(ORB + 8, 1'b1, "R2");
    idle(4, 1'b0, "R2");
    setbit(MDB + 4, 1'b1, "R2");
    idle(4, 1'b0, "R2");
    // R3: first term of output 9 (term 104) with literal in21 true
    setbit(104*44 + 42, 1'b1, "R3");
    setbit(ORB + 104, 1'b1, "R3");
    idle(10, 1'b0, "R3");
    // R6: walk all four modes of output 0
    for (int m = 0; m < 4; m++) begin
      setbit(MDB + 0, m[0], "R6");
      setbit(MDB + 1, m[1], "R6");
      idle(8, 1'b0, "R6");
    end
    // R7: registered true on output 0, hold toggling
    setbit(MDB + 0, 1'b0, "R7");
    setbit(MDB + 1, 1'b1, "R7");
    for (int i = 0; i < 40; i++) cyc(1'b0, 0, 0, (i % 5) < 2, 22'($urandom), "R7");
    // R5: out-of-range writes and padding bits
    cyc(1'b1, 170, 32'hFFFF_FFFF, 1'b0, 22'($urandom), "R5");
    cyc(1'b1, 200, 32'hFFFF_FFFF, 1'b0, 22'($urandom), "R5");
    cyc(1'b1, 255, 32'hFFFF_FFFF, 1'b0, 22'($urandom), "R5");
    idle(4, 1'b0, "R5");
    cyc(1'b1, 169, 32'hFFFF_FFFF, 1'b0, 22'($urandom), "R5");
    idle(8, 1'b1, "R5");
    idle(8, 1'b0, "R5");
    // R4/R8: full random contexts streamed while the array runs
    for (int f = 0; f < 6; f++) begin
      for (int a = 0; a < NW; a++) begin
        logic [31:0] w;
        w = (a < 165) ? ($urandom & $urandom & $urandom & $urandom) : $urandom;
        cyc(1'b1, a, w, f[0], 22'($urandom), "R8");
      end
      for (int i = 0; i < 60; i++)
        cyc(1'b0, 0, 0, ($urandom % 4) == 0, 22'($urandom), "R4");
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule